// File: doc/BRIEF.md
# Read-Chain Command Unlock Detector

This block sits beside an asynchronous SRAM-style bus and watches each chip-enable access once, as the bus interface reports it on a one-cycle strobe in the system clock domain. It looks for one exact run of six consecutive read accesses. The first five addresses are the same for both commands. The sixth address picks the command: a nonvolatile save (store) or a nonvolatile restore (recall). When the run completes, the block raises a one-cycle request pulse that names the command. A separate engine carries out the command, and the block does not time it.

Any access that breaks the run, whether it is a write or a read from another address, throws away the progress made so far. That access is then tested again as a possible first step of a new run. While the external engine reports busy, the detector stays in its idle state and ignores every access. The access interface has no back-pressure: each strobe is one bus access that has already taken place, so the detector always takes it in the cycle it appears and has no ready signal. The request outputs are plain level pulses with no handshake.

Top module: `nv_unlock_seq`

## Requirements
- R1: After reset the detector is idle and holds no partial match. Both request outputs are low, and the last five addresses of a run, presented alone, produce no request.
- R2: Six consecutive read accesses (write enable high) to 0x0E38, 0x31C7, 0x03E0, 0x3C1F, 0x303F and then 0x0FC0 raise `store_req` for exactly one cycle. The pulse starts in the cycle after the clock edge that samples the sixth strobe.
- R3: The same five-address prefix followed by a read of 0x0C63 raises `recall_req` for exactly one cycle, with the same timing as R2.
- R4: Only address bits 13:0 take part in the compare. Bit 14 may take any value on any step without affecting the result.
- R5: A write access (write enable low) at any step aborts the run. It never counts as a step, so no request follows from the accesses that completed the run it broke.
- R6: A read from any address other than the one expected at the current step aborts the run, and no request is issued.
- R7: An access that aborts a run is tested again as a first step. A read of 0x0E38 that breaks a run leaves the detector expecting 0x31C7 next.
- R8: While `busy` is high the detector returns to idle. Any run in progress is lost, and strobes are ignored without any effect.
- R9: After a request pulse the detector is idle. Repeating the sixth address alone issues nothing.
- R10: Clock cycles without a strobe neither advance nor break a run, so idle gaps between the accesses are allowed.
- R11: `store_req` and `recall_req` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_strobe | input | 1 | One-cycle marker of one completed chip-enable access |
| acc_addr | input | 15 | Address of the access, valid with `acc_strobe` |
| acc_we_n | input | 1 | Write-enable level of the access, low for a write |
| busy | input | 1 | High while the store/recall engine is working |
| store_req | output | 1 | One-cycle store command pulse |
| recall_req | output | 1 | One-cycle recall command pulse |

## Verification
The bench targets four kinds of run: runs broken at every step by a write, by a stray read or by busy; runs broken by 0x0E38 that must restart at the second step; runs with bit 14 set; and a sixth address repeated straight after a pulse. A detector that failed to re-test the aborting access would miss the restarted store. A detector that compared all 15 bits would stay silent on runs with bit 14 set. One that did not clear after a pulse, or that let a write count as a step, would issue an extra command. Random accesses mixed with partly corrupted runs, checked every cycle against a reference model, catch a counter that slips on idle cycles or fires both pulses.

// File: rtl/nvu_pkg.sv
package nvu_pkg;
  localparam int ADDR_W   = 15;
  localparam int CMP_W    = 14;
  localparam int STEPS    = 6;
  localparam int PREFIX_N = STEPS - 1;
  localparam int CNT_W    = $clog2(STEPS);

  localparam logic [CMP_W-1:0] KEY_STORE  = 14'h0FC0;
  localparam logic [CMP_W-1:0] KEY_RECALL = 14'h0C63;

  typedef enum logic [1:0] {
    CMD_NONE   = 2'd0,
    CMD_STORE  = 2'd1,
    CMD_RECALL = 2'd2
  } cmd_e;

  function automatic logic [CMP_W-1:0] prefix_key(input int idx);
    case (idx)
      0:       prefix_key = 14'h0E38;
      1:       prefix_key = 14'h31C7;
      2:       prefix_key = 14'h03E0;
      3:       prefix_key = 14'h3C1F;
      default: prefix_key = 14'h303F;
    endcase
  endfunction
endpackage

// File: rtl/nvu_key_match.sv
module nvu_key_match
  import nvu_pkg::*;
(
  input  logic [ADDR_W-1:0]   addr,
  output logic [PREFIX_N-1:0] prefix_hit,
  output logic                store_hit,
  output logic                recall_hit
);
  logic [CMP_W-1:0] low_addr;
  assign low_addr = addr[CMP_W-1:0];

  for (genvar g = 0; g < PREFIX_N; g++) begin : g_prefix
    assign prefix_hit[g] = (low_addr == prefix_key(g));
  end

  assign store_hit  = (low_addr == KEY_STORE);
  assign recall_hit = (low_addr == KEY_RECALL);

  always_comb begin
    assert (!(store_hit && recall_hit));
  end
endmodule

// File: rtl/nvu_seq_fsm.sv
module nvu_seq_fsm
  import nvu_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                strobe,
  input  logic                we_n,
  input  logic                busy,
  input  logic [PREFIX_N-1:0] prefix_hit,
  input  logic                store_hit,
  input  logic                recall_hit,
  output cmd_e                cmd_q
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PREFIX_N);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  cmd_e             cmd_d;
  logic             step_hit;

  always_comb begin
    step_hit = 1'b0;
    for (int i = 0; i < PREFIX_N; i++) begin
      if (cnt_q == CNT_W'(i)) step_hit = prefix_hit[i];
    end
  end

  always_comb begin
    cnt_d = cnt_q;
    cmd_d = CMD_NONE;
    if (busy) begin
      cnt_d = '0;
    end else if (strobe) begin
      if (!we_n) begin
        cnt_d = '0;
      end else if (cnt_q == LAST && store_hit) begin
        cmd_d = CMD_STORE;
        cnt_d = '0;
      end else if (cnt_q == LAST && recall_hit) begin
        cmd_d = CMD_RECALL;
        cnt_d = '0;
      end else if (cnt_q != LAST && step_hit) begin
        cnt_d = cnt_q + 1'b1;
      end else begin
        cnt_d = prefix_hit[0] ? CNT_W'(1) : '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      cmd_q <= CMD_NONE;
    end else begin
      cnt_q <= cnt_d;
      cmd_q <= cmd_d;
    end
  end

  AST_CMD_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_q inside {CMD_NONE, CMD_STORE, CMD_RECALL}); // R11
  AST_BUSY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (cnt_q == '0 && cmd_q == CMD_NONE)); // R8
  AST_WRITE_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !we_n) |=> (cnt_q == '0 && cmd_q == CMD_NONE)); // R5
  AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe && !busy) |=> ($stable(cnt_q) && cmd_q == CMD_NONE)); // R10
  AST_CMD_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && we_n && !busy && cnt_q != LAST) |=> cmd_q == CMD_NONE); // R2
  AST_CMD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q != CMD_NONE) |=> (cmd_q == CMD_NONE)); // R9
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST); // R1
endmodule

// File: rtl/nv_unlock_seq.sv
module nv_unlock_seq
  import nvu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_strobe,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_we_n,
  input  logic              busy,
  output logic              store_req,
  output logic              recall_req
);
  logic [PREFIX_N-1:0] prefix_hit;
  logic                store_hit;
  logic                recall_hit;
  cmd_e                cmd_q;

  nvu_key_match u_match (
    .addr       (acc_addr),
    .prefix_hit (prefix_hit),
    .store_hit  (store_hit),
    .recall_hit (recall_hit)
  );

  nvu_seq_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (acc_strobe),
    .we_n       (acc_we_n),
    .busy       (busy),
    .prefix_hit (prefix_hit),
    .store_hit  (store_hit),
    .recall_hit (recall_hit),
    .cmd_q      (cmd_q)
  );

  assign store_req  = (cmd_q == CMD_STORE);
  assign recall_req = (cmd_q == CMD_RECALL);

  AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(store_req && recall_req)); // R11
  AST_NO_REQ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !(store_req || recall_req)); // R8
endmodule

// File: tb/nv_unlock_seq_tb_top.sv
module nv_unlock_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_strobe = 1'b0;
  logic [14:0] acc_addr = '0;
  logic acc_we_n = 1'b1;
  logic busy = 1'b0;
  logic store_req, recall_req;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  int m_cnt = 0;
  bit exp_st = 0;
  bit exp_rc = 0;

  always #5 clk = ~clk;

  nv_unlock_seq dut_i (
    .clk(clk), .rst_n(rst_n), .acc_strobe(acc_strobe), .acc_addr(acc_addr),
    .acc_we_n(acc_we_n), .busy(busy), .store_req(store_req), .recall_req(recall_req)
  );

  function automatic logic [13:0] key(input int k);
    case (k)
      0: key = 14'h0E38; 1: key = 14'h31C7; 2: key = 14'h03E0;
      3: key = 14'h3C1F; 4: key = 14'h303F; 5: key = 14'h0FC0;
      default: key = 14'h0C63;
    endcase
  endfunction

  // Reference model built from R2..R10
  task automatic model(input bit s, input logic [14:0] a, input bit we, input bit b);
    logic [13:0] lo = a[13:0];
    exp_st = 0; exp_rc = 0;
    if (b) m_cnt = 0;
    else if (s) begin
      if (!we) m_cnt = 0;
      else if (m_cnt == 5 && lo == key(5)) begin exp_st = 1; m_cnt = 0; end
      else if (m_cnt == 5 && lo == key(6)) begin exp_rc = 1; m_cnt = 0; end
      else if (m_cnt < 5 && lo == key(m_cnt)) m_cnt = m_cnt + 1;
      else m_cnt = (lo == key(0)) ? 1 : 0;
    end
  endtask

  task automatic check(input string tag);
    checks++;
    if (store_req !== exp_st || recall_req !== exp_rc) begin
      fails++;
      $display("FAIL %s: store/recall actual %b%b expected %b%b", tag,
               store_req, recall_req, exp_st, exp_rc);
    end
  endtask

  // one cycle: drive at negedge, check at the following negedge
  task automatic tick(input bit s, input logic [14:0] a, input bit we, input bit b,
                      input string tag);
    acc_strobe = s; acc_addr = a; acc_we_n = we; busy = b;
    model(s, a, we, b);
    @(negedge clk);
    acc_strobe = 0; busy = 0;
    check(tag);
  endtask

  task automatic rd(input logic [13:0] a, input string tag);
    tick(1, {1'b0, a}, 1, 0, tag);
  endtask

  task automatic chain(input int last, input string tag);
    for (int k = 0; k < 5; k++) rd(key(k), tag);
    rd(key(last), tag);
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    exp_st = 0; exp_rc = 0;
    check("R1 reset");
    @(negedge clk);
    rst_n = 1;
    check("R1 reset");
    // R1: tail of a run alone produces nothing
    for (int k = 1; k < 6; k++) rd(key(k), "R1 no partial");
    chain(5, "R2 store");
    chain(6, "R3 recall");
    // R4: bit 14 set on every step
    for (int k = 0; k < 6; k++) tick(1, {1'b1, key(k)}, 1, 0, "R4 bit14");
    // R5: write at step 3 then the rest of the run
    for (int k = 0; k < 3; k++) rd(key(k), "R5 write abort");
    tick(1, {1'b0, key(3)}, 0, 0, "R5 write abort");
    for (int k = 4; k < 6; k++) rd(key(k), "R5 write abort");
    // R6: stray read at step 4
    for (int k = 0; k < 4; k++) rd(key(k), "R6 stray read");
    rd(14'h1234, "R6 stray read");
    rd(key(4), "R6 stray read"); rd(key(5), "R6 stray read");
    // R7: 0x0E38 breaks a run and restarts it
    rd(key(0), "R7 restart"); rd(key(1), "R7 restart"); rd(key(0), "R7 restart");
    for (int k = 1; k < 6; k++) rd(key(k), "R7 restart");
    // R7 at the sixth step
    for (int k = 0; k < 5; k++) rd(key(k), "R7 sixth restart");
    rd(key(0), "R7 sixth restart");
    for (int k = 1; k < 5; k++) rd(key(k), "R7 sixth restart");
    rd(key(6), "R7 sixth restart");
    // R9: repeat sixth address after pulse
    chain(5, "R9 repeat"); rd(key(5), "R9 repeat"); rd(key(6), "R9 repeat");
    // R8: busy with strobe mid run, then busy alone
    for (int k = 0; k < 3; k++) rd(key(k), "R8 busy");
    tick(1, {1'b0, key(3)}, 1, 1, "R8 busy");
    for (int k = 4; k < 6; k++) rd(key(k), "R8 busy");
    for (int k = 0; k < 5; k++) rd(key(k), "R8 busy gap");
    tick(0, '0, 1, 1, "R8 busy gap");
    rd(key(5), "R8 busy gap");
    // R10: idle gaps inside a run
    for (int k = 0; k < 6; k++) begin
      rd(key(k), "R10 gaps");
      tick(0, 15'h7FFF, 0, 0, "R10 gaps");
      tick(0, '0, 1, 0, "R10 gaps");
    end
    // Random mix, R11 checked on every cycle via check()
    for (int it = 0; it < 600; it++) begin
      if ($urandom_range(0, 2) == 0) begin
        tick($urandom_range(0, 1), 15'($urandom), $urandom_range(0, 3) != 0,
             $urandom_range(0, 9) == 0, "R11 random");
      end else begin
        int last = $urandom_range(5, 6);
        for (int k = 0; k < 6; k++) begin
          logic [13:0] a = (k == 5) ? key(last) : key(k);
          bit we = 1, b = 0;
          int r = $urandom_range(0, 29);
          if (r == 0) a = 14'($urandom);
          if (r == 1) we = 0;
          if (r == 2) b = 1;
          if (r == 3) a = key(0);
          tick(1, {1'($urandom), a}, we, b, "R11 random run");
          for (int g = $urandom_range(0, 1); g > 0; g--)
            tick(0, 15'($urandom), 1'($urandom), 0, "R11 random gap");
        end
      end
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule